// File: doc/BRIEF.md
# Register Interlock and Forwarding Unit

This block is the hazard controller for an in-order integer pipeline with the stages fetch, decode, operand fetch, execute and write-back. Each cycle the decode stage presents its instruction: two source register numbers with use flags, a destination number with a write flag, and a load flag. The block answers in the same cycle with a stall request. When it does not stall, it registers one operand-mux select per source. Those selects steer the operand-fetch stage in the next cycle.

Internally the block keeps a shadow copy of the destination tags of the three older instructions that sit in operand fetch, execute and write-back. It also keeps a per-register pending-writer count, whose non-zero state is the register's lock bit. A source that reads a locked register is served from one of three places. The ALU output tap is used when the producer will be in execute, provided early forwarding is enabled. The write-back bus tap is used when the producer will be in write-back. In every other case decode is held until the lock clears. A load producer is never forwarded. A single mode input turns the ALU tap on or off, so that the same instruction stream can be run with early or late forwarding and the stall counts compared.

Top module: `hz_interlock_unit`

## Requirements
- R1: After reset, and after any later reset, every lock is clear and no earlier instruction is tracked. `stall` is 0, and both selects read 0 until an instruction with a dependency issues.
- R2: Two instructions that only read the same registers (read after read), or that have no common register, never stall and get select 0 (register file).
- R3: Select codes: 0 = register file, 1 = ALU output, 2 = write-back bus. A select appears one cycle after its instruction issues. With `fwd_early`=1, a source that depends on the instruction issued one cycle earlier, a non-load, issues without a stall and gets select 1.
- R4: With `fwd_early`=0 the ALU tap is never chosen. The same back-to-back dependency stalls exactly one cycle, then issues with select 2. During a stall cycle a bubble enters and the next-cycle selects are 0.
- R5: A source that depends on a non-load issued two instructions earlier issues without a stall and gets select 2, in both modes.
- R6: A load result is never forwarded. A dependent at distance one stalls two cycles, and one at distance two stalls one cycle. Either then issues with select 0, in both modes.
- R7: Register 0 is never locked. Reading it never stalls, even straight after an instruction that names it as destination.
- R8: When several in-flight instructions write the register a source reads, the youngest of them decides whether to forward or stall, and which tap to use.
- R9: A register stays locked until its last pending writer has retired from write-back. An older writer retiring does not release it.
- R10: A source whose use flag is 0 never causes a stall and gets select 0.
- R11: A decode slot with `dec_valid`=0 locks nothing, is not tracked and never stalls.
- R12: The two sources are resolved independently, each with its own tap, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fwd_early | input | 1 | 1 enables the ALU output tap; 0 leaves only the write-back tap |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_rs1 | input | RW | First source register number |
| dec_use1 | input | 1 | First source is read |
| dec_rs2 | input | RW | Second source register number |
| dec_use2 | input | 1 | Second source is read |
| dec_rd | input | RW | Destination register number |
| dec_wr | input | 1 | Instruction writes its destination |
| dec_load | input | 1 | Instruction is a load |
| stall | output | 1 | Hold decode this cycle (combinational) |
| op1_sel | output | 2 | Operand-fetch mux select for source 1 (registered) |
| op2_sel | output | 2 | Operand-fetch mux select for source 2 (registered) |

## Verification
`stall` answers the decode inputs in the same cycle, with no register on the way. Each select goes through exactly one register, so it shows the decision for the instruction issued in the previous cycle, and 0 after a stall or an empty slot. The driver applies inputs on the falling edge and queues one expected item for that cycle. The item holds the stall level due now and the selects due from the previous cycle's issue. The monitor samples 1 ns after that falling edge, so every value is read after it has settled and before the next rising edge. Stall lengths are checked by holding the stalled instruction in decode and expecting each repeat cycle explicitly.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
// Shared encodings of the interlock unit.
// Assumes: select codes are decoded by the operand-fetch mux as listed here.
package hz_pkg;
    typedef enum logic [1:0] {
        SEL_RF  = 2'd0,
        SEL_ALU = 2'd1,
        SEL_WB  = 2'd2
    } opsel_e;
endpackage

// File: rtl/hz_shadow_pipe.sv
`timescale 1ns/1ps
// Shadow of the destination tags of instructions behind decode.
// Stage 0 = operand fetch, 1 = execute, DEPTH-1 = write-back.
// Assumes: the pipeline behind decode never stalls, so tags advance every cycle.
module hz_shadow_pipe #(
    parameter int unsigned RW    = 5,
    parameter int unsigned DEPTH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue,
    input  logic [RW-1:0]         in_rd,
    input  logic                  in_wr,
    input  logic                  in_ld,
    output logic [DEPTH-1:0]      stg_wr,
    output logic [DEPTH-1:0]      stg_ld,
    output logic [DEPTH*RW-1:0]   stg_rd
);
    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                // Capture the issuing instruction, or a bubble.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        stg_wr[0]      <= 1'b0;
                        stg_ld[0]      <= 1'b0;
                        stg_rd[RW-1:0] <= '0;
                    end else begin
                        stg_wr[0]      <= issue && in_wr;
                        stg_ld[0]      <= issue && in_ld;
                        stg_rd[RW-1:0] <= in_rd;
                    end
                end
            end else begin : g_body
                // Advance the previous stage's tag.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        stg_wr[i]             <= 1'b0;
                        stg_ld[i]             <= 1'b0;
                        stg_rd[i*RW +: RW]    <= '0;
                    end else begin
                        stg_wr[i]             <= stg_wr[i-1];
                        stg_ld[i]             <= stg_ld[i-1];
                        stg_rd[i*RW +: RW]    <= stg_rd[(i-1)*RW +: RW];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/hz_lock_table.sv
`timescale 1ns/1ps
// Per-register pending-writer counts; a non-zero count is the lock bit.
// Assumes: at most 2**CW-1 writers of one register are in flight; register 0 is hardwired free.
module hz_lock_table #(
    parameter int unsigned NREG = 32,
    parameter int unsigned RW   = 5,
    parameter int unsigned CW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc_en,
    input  logic [RW-1:0]   inc_rd,
    input  logic            ret_en,
    input  logic [RW-1:0]   ret_rd,
    output logic [NREG-1:0] locked,
    output logic [NREG-1:0] last_one
);
    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_reg
            if (r == 0) begin : g_zero
                assign locked[0]   = 1'b0;
                assign last_one[0] = 1'b0;
            end else begin : g_cnt
                logic [CW-1:0] cnt;
                logic          up;
                logic          down;
                assign up   = inc_en && (inc_rd == RW'(r));
                assign down = ret_en && (ret_rd == RW'(r));
                // Count writers entering minus writers retiring.
                always_ff @(posedge clk) begin
                    if (!rst_n) cnt <= '0;
                    else        cnt <= cnt + CW'(up) - CW'(down);
                end
                assign locked[r]   = (cnt != '0);
                assign last_one[r] = (cnt == CW'(1));
            end
        end
    endgenerate
endmodule

// File: rtl/hz_src_resolve.sv
`timescale 1ns/1ps
// Resolves one decode source: free, forward from a tap, or stall.
// Assumes: stage 0 producer is in execute next cycle, stage 1 producer in write-back.
module hz_src_resolve #(
    parameter int unsigned NREG = 32,
    parameter int unsigned RW   = 5
) (
    input  logic            use_src,
    input  logic [RW-1:0]   rs,
    input  logic [NREG-1:0] locked,
    input  logic [NREG-1:0] last_one,
    input  logic            ret_en,
    input  logic [RW-1:0]   ret_rd,
    input  logic            s0_wr,
    input  logic            s0_ld,
    input  logic [RW-1:0]   s0_rd,
    input  logic            s1_wr,
    input  logic            s1_ld,
    input  logic [RW-1:0]   s1_rd,
    input  logic            fwd_early,
    output logic            need_stall,
    output hz_pkg::opsel_e  sel
);
    import hz_pkg::*;
    logic hit0, hit1, retiring, pending;

    assign hit0     = s0_wr && (s0_rd == rs) && (rs != '0);
    assign hit1     = s1_wr && (s1_rd == rs) && (rs != '0);
    assign retiring = ret_en && (ret_rd == rs);
    assign pending  = locked[rs] && !(last_one[rs] && retiring);

    // Youngest producer decides the tap; a load or a disabled tap stalls.
    always_comb begin
        need_stall = 1'b0;
        sel        = SEL_RF;
        if (use_src && pending) begin
            if (hit0) begin
                sel        = SEL_ALU;
                need_stall = !fwd_early || s0_ld;
            end else if (hit1) begin
                sel        = SEL_WB;
                need_stall = s1_ld;
            end else begin
                need_stall = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hz_interlock_unit.sv
`timescale 1ns/1ps
// Top: lock-bit scoreboard plus two forwarding taps for decode.
// Assumes: decode holds its instruction while stall is high; stall is combinational.
module hz_interlock_unit #(
    parameter int unsigned NREG  = 32,
    parameter int unsigned DEPTH = 3,
    localparam int unsigned RW   = $clog2(NREG),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwd_early,
    input  logic          dec_valid,
    input  logic [RW-1:0] dec_rs1,
    input  logic          dec_use1,
    input  logic [RW-1:0] dec_rs2,
    input  logic          dec_use2,
    input  logic [RW-1:0] dec_rd,
    input  logic          dec_wr,
    input  logic          dec_load,
    output logic          stall,
    output logic [1:0]    op1_sel,
    output logic [1:0]    op2_sel
);
    import hz_pkg::*;

    logic [DEPTH-1:0]    stg_wr, stg_ld;
    logic [DEPTH*RW-1:0] stg_rd;
    logic [NREG-1:0]     locked, last_one;
    logic                issue, wr_eff, ret_en;
    logic [RW-1:0]       ret_rd;
    logic [1:0]          src_stall;
    opsel_e              src_sel [2];
    logic [RW-1:0]       src_rs  [2];
    logic [1:0]          src_use;

    assign wr_eff = dec_wr && (dec_rd != '0);
    assign issue  = dec_valid && !stall;
    assign ret_en = stg_wr[DEPTH-1];
    assign ret_rd = stg_rd[(DEPTH-1)*RW +: RW];
    assign src_rs[0] = dec_rs1;
    assign src_rs[1] = dec_rs2;
    assign src_use   = {dec_use2, dec_use1};

    hz_shadow_pipe #(.RW(RW), .DEPTH(DEPTH)) u_pipe (
        .clk(clk), .rst_n(rst_n), .issue(issue),
        .in_rd(dec_rd), .in_wr(wr_eff), .in_ld(dec_load),
        .stg_wr(stg_wr), .stg_ld(stg_ld), .stg_rd(stg_rd)
    );

    hz_lock_table #(.NREG(NREG), .RW(RW), .CW(CW)) u_locks (
        .clk(clk), .rst_n(rst_n),
        .inc_en(issue && wr_eff), .inc_rd(dec_rd),
        .ret_en(ret_en), .ret_rd(ret_rd),
        .locked(locked), .last_one(last_one)
    );

    genvar s;
    generate
        for (s = 0; s < 2; s++) begin : g_src
            hz_src_resolve #(.NREG(NREG), .RW(RW)) u_res (
                .use_src(src_use[s]), .rs(src_rs[s]),
                .locked(locked), .last_one(last_one),
                .ret_en(ret_en), .ret_rd(ret_rd),
                .s0_wr(stg_wr[0]), .s0_ld(stg_ld[0]), .s0_rd(stg_rd[RW-1:0]),
                .s1_wr(stg_wr[1]), .s1_ld(stg_ld[1]), .s1_rd(stg_rd[RW +: RW]),
                .fwd_early(fwd_early),
                .need_stall(src_stall[s]), .sel(src_sel[s])
            );
        end
    endgenerate

    assign stall = dec_valid && (src_stall != 2'b00);

    // Register the selects for the operand-fetch cycle; bubbles read the file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op1_sel <= SEL_RF;
            op2_sel <= SEL_RF;
        end else begin
            op1_sel <= issue ? src_sel[0] : SEL_RF;
            op2_sel <= issue ? src_sel[1] : SEL_RF;
        end
    end
endmodule

// File: rtl/hz_interlock_chk.sv
`timescale 1ns/1ps
// Checker for the interlock unit, attached by bind.
// Assumes: select codes as in hz_pkg.
module hz_interlock_chk #(
    parameter int unsigned RW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fwd_early,
    input logic          dec_valid,
    input logic [RW-1:0] dec_rs1,
    input logic          dec_use1,
    input logic [RW-1:0] dec_rs2,
    input logic          dec_use2,
    input logic          stall,
    input logic [1:0]    op1_sel,
    input logic [1:0]    op2_sel
);
    AST_SEL_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op1_sel != 2'd3) && (op2_sel != 2'd3)); // R3

    AST_NO_ALU_TAP_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_early |=> (op1_sel != 2'd1) && (op2_sel != 2'd1)); // R4

    AST_BUBBLE_READS_FILE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (op1_sel == 2'd0) && (op2_sel == 2'd0)); // R4

    AST_EMPTY_SLOT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !stall); // R11

    AST_ZERO_OR_UNUSED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ((!dec_use1 || dec_rs1 == '0) && (!dec_use2 || dec_rs2 == '0)) |-> !stall); // R7
endmodule

bind hz_interlock_unit hz_interlock_chk #(.RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fwd_early(fwd_early), .dec_valid(dec_valid),
    .dec_rs1(dec_rs1), .dec_use1(dec_use1), .dec_rs2(dec_rs2), .dec_use2(dec_use2),
    .stall(stall), .op1_sel(op1_sel), .op2_sel(op2_sel)
);

// File: tb/tb_hz_interlock_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: driver queues one expected item per cycle, monitor compares.
module tb_hz_interlock_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fwd_early = 1'b1;
    logic       dec_valid = 1'b0;
    logic [4:0] dec_rs1 = '0, dec_rs2 = '0, dec_rd = '0;
    logic       dec_use1 = 1'b0, dec_use2 = 1'b0, dec_wr = 1'b0, dec_load = 1'b0;
    logic       stall;
    logic [1:0] op1_sel, op2_sel;

    typedef struct {
        logic       es;
        logic [1:0] e1;
        logic [1:0] e2;
        string      tag;
    } exp_t;
    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #2.5 clk = ~clk;

    hz_interlock_unit dut (
        .clk(clk), .rst_n(rst_n), .fwd_early(fwd_early), .dec_valid(dec_valid),
        .dec_rs1(dec_rs1), .dec_use1(dec_use1), .dec_rs2(dec_rs2), .dec_use2(dec_use2),
        .dec_rd(dec_rd), .dec_wr(dec_wr), .dec_load(dec_load),
        .stall(stall), .op1_sel(op1_sel), .op2_sel(op2_sel)
    );

    // Drive one cycle of decode input and queue what is due in that cycle.
    task automatic cyc(input logic r, input logic v,
                       input logic [4:0] a, input logic ua,
                       input logic [4:0] b, input logic ub,
                       input logic [4:0] d, input logic w, input logic ld,
                       input logic es, input logic [1:0] e1, input logic [1:0] e2,
                       input string tag);
        exp_t it;
        @(negedge clk);
        rst_n = !r; dec_valid = v;
        dec_rs1 = a; dec_use1 = ua; dec_rs2 = b; dec_use2 = ub;
        dec_rd = d; dec_wr = w; dec_load = ld;
        it.es = es; it.e1 = e1; it.e2 = e2; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic nop(input logic [1:0] e1, input logic [1:0] e2, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, e1, e2, tag);
    endtask

    task automatic drain();
        for (int k = 0; k < 4; k++) nop(0, 0, "drain");
    endtask

    // Monitor: compare outputs shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                checks++;
                if (stall !== it.es || op1_sel !== it.e1 || op2_sel !== it.e2) begin
                    fails++;
                    $display("FAIL %s: stall/op1/op2 actual %0b/%0d/%0d expected %0b/%0d/%0d",
                             it.tag, stall, op1_sel, op2_sel, it.es, it.e1, it.e2);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(5.0 * 20000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: state under and right after reset
        cyc(1, 0, 0,0, 0,0, 0,0,0, 0, 0, 0, "R1");
        cyc(1, 0, 0,0, 0,0, 0,0,0, 0, 0, 0, "R1");
        nop(0, 0, "R1");
        // R1: a reset in flight drops the pending writer of r7
        fwd_early = 1'b1;
        cyc(0, 1, 1,1, 2,1, 7,1,0, 0, 0, 0, "R1");
        cyc(1, 0, 0,0, 0,0, 0,0,0, 0, 0, 0, "R1");
        cyc(0, 1, 7,1, 0,0, 3,1,0, 0, 0, 0, "R1");
        nop(0, 0, "R1");
        drain();

        // R2: read after read shares r1/r2 without a stall
        cyc(0, 1, 1,1, 2,1, 3,1,0, 0, 0, 0, "R2");
        cyc(0, 1, 1,1, 2,1, 4,1,0, 0, 0, 0, "R2");
        nop(0, 0, "R2");
        drain();

        // R3: early mode, back-to-back dependency uses the ALU tap
        cyc(0, 1, 1,1, 2,1, 5,1,0, 0, 0, 0, "R3");
        cyc(0, 1, 5,1, 6,1, 9,1,0, 0, 0, 0, "R3");
        nop(1, 0, "R3");
        drain();

        // R12: early mode, ALU tap on source 1 and write-back tap on source 2
        cyc(0, 1, 1,1, 2,1, 7,1,0, 0, 0, 0, "R12");
        cyc(0, 1, 1,1, 2,1, 8,1,0, 0, 0, 0, "R12");
        cyc(0, 1, 8,1, 7,1, 9,1,0, 0, 0, 0, "R12");
        nop(1, 2, "R12");
        drain();

        // R8: youngest writer (non-load) wins over older load to r4
        cyc(0, 1, 1,1, 2,1, 4,1,1, 0, 0, 0, "R8");
        cyc(0, 1, 1,1, 2,1, 4,1,0, 0, 0, 0, "R8");
        cyc(0, 1, 4,1, 0,0, 9,1,0, 0, 0, 0, "R8");
        nop(1, 0, "R8");
        drain();

        // R6: early mode, load-use at distance one stalls two cycles
        cyc(0, 1, 1,1, 2,1, 9,1,1, 0, 0, 0, "R6");
        cyc(0, 1, 9,1, 0,0, 3,1,0, 1, 0, 0, "R6");
        cyc(0, 1, 9,1, 0,0, 3,1,0, 1, 0, 0, "R6");
        cyc(0, 1, 9,1, 0,0, 3,1,0, 0, 0, 0, "R6");
        nop(0, 0, "R6");
        drain();

        // Late forwarding from here on
        fwd_early = 1'b0;
        drain();

        // R4: late mode, back-to-back dependency stalls one cycle then uses write-back
        cyc(0, 1, 1,1, 2,1, 5,1,0, 0, 0, 0, "R4");
        cyc(0, 1, 5,1, 6,1, 9,1,0, 1, 0, 0, "R4");
        cyc(0, 1, 5,1, 6,1, 9,1,0, 0, 0, 0, "R4");
        nop(2, 0, "R4");
        drain();

        // R5: late mode, distance two uses write-back without a stall
        cyc(0, 1, 1,1, 2,1, 7,1,0, 0, 0, 0, "R5");
        cyc(0, 1, 1,1, 2,1, 8,1,0, 0, 0, 0, "R5");
        cyc(0, 1, 1,1, 7,1, 9,1,0, 0, 0, 0, "R5");
        nop(0, 2, "R5");
        drain();

        // R6: late mode, load-use at distance two stalls one cycle
        cyc(0, 1, 1,1, 2,1, 9,1,1, 0, 0, 0, "R6");
        cyc(0, 1, 1,1, 2,1, 10,1,0, 0, 0, 0, "R6");
        cyc(0, 1, 1,1, 9,1, 3,1,0, 1, 0, 0, "R6");
        cyc(0, 1, 1,1, 9,1, 3,1,0, 0, 0, 0, "R6");
        nop(0, 0, "R6");
        drain();

        // R7: register 0 as destination of a load never locks
        cyc(0, 1, 1,1, 2,1, 0,1,1, 0, 0, 0, "R7");
        cyc(0, 1, 0,1, 0,1, 3,1,0, 0, 0, 0, "R7");
        nop(0, 0, "R7");
        drain();

        // R9: r4 written by a non-load then a load; lock lasts until the load retires
        cyc(0, 1, 1,1, 2,1, 4,1,0, 0, 0, 0, "R9");
        cyc(0, 1, 1,1, 2,1, 4,1,1, 0, 0, 0, "R9");
        cyc(0, 1, 4,1, 0,0, 9,1,0, 1, 0, 0, "R9");
        cyc(0, 1, 4,1, 0,0, 9,1,0, 1, 0, 0, "R9");
        cyc(0, 1, 4,1, 0,0, 9,1,0, 0, 0, 0, "R9");
        nop(0, 0, "R9");
        drain();

        // R10: unused sources naming a locked register do not stall
        cyc(0, 1, 1,1, 2,1, 5,1,0, 0, 0, 0, "R10");
        cyc(0, 1, 5,0, 5,0, 9,1,0, 0, 0, 0, "R10");
        nop(0, 0, "R10");
        drain();

        // R11: an empty decode slot carrying rd=6 locks nothing
        cyc(0, 0, 1,1, 2,1, 6,1,0, 0, 0, 0, "R11");
        cyc(0, 1, 6,1, 6,1, 9,1,0, 0, 0, 0, "R11");
        nop(0, 0, "R11");
        drain();

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule